// File: doc/BRIEF.md
# Prioritized Interrupt Claim/Complete Controller

This block collects level-sensitive interrupt requests from a parameterized set of sources and hands them out to a set of target contexts, two by default. Each source passes through its own gateway. The gateway latches a request as pending, keeps it out of circulation once a target has claimed it, and re-arms only when a valid completion arrives. Software programs a priority for each source, an enable mask for each target, and a priority threshold for each target. It does this through a flat configuration port. Each target raises its request line whenever a suitable source is waiting.

Each target has its own claim strobe and completion strobe. A claim returns the best waiting source for that target and removes that source from pending in the same clock edge. A completion writes a source ID back and re-opens the source's gateway. A mode input selects between two claim behaviours. In compliant behaviour, a claim only consumes the pending request. In mask-on-claim behaviour, a claim also clears the claiming target's enable bit for that source. Software running that variant must therefore re-enable the source before it completes.

Top module: `pcc_top`

## Requirements
- R1: After reset, both claim data outputs read 0, every irq line is low, and every configuration register reads 0.
- R2: A source whose input is high while its gateway is idle becomes pending on the next clock edge. A claim returns the ID (sources are numbered 1..NUM_SRC, and input bit k is ID k+1) of the pending source that is enabled for that target and has the highest nonzero priority. Equal priorities go to the lower ID. The target threshold does not filter claims. The claim returns 0 when no source qualifies, and a source with priority 0 is never returned.
- R3: irq[t] is high exactly when the highest priority among sources that are pending and enabled for target t is strictly greater than target t's threshold.
- R4: A claim clears the source's pending state on the same edge. The source is then held: while held, it is not returned to any target, even with its input still high.
- R5: A completion for ID n from target t releases source n only if bit n-1 of target t's enable mask is set in that cycle. A completion for ID 0, or for a disabled ID, has no effect, and the source stays held.
- R6: After a valid completion, the source's gateway is idle on the next edge. If the input is still high, the source becomes pending one edge after that.
- R7: A held source blocks only itself. Other sources still become pending and still drive the irq of any target that enables them.
- R8: When both targets claim in the same cycle, target 0 gets its best source. Target 1 gets its best source other than that one, or 0.
- R9: With quirkMode low, a claim leaves every enable mask unchanged. With quirkMode high, a claim by target t clears bit n-1 of target t's enable mask only, where n is the claimed ID.
- R10: The configuration map is as follows. Address n (1..NUM_SRC) holds the priority of ID n. Address 0x20+t holds target t's enable mask. Address 0x30+t holds target t's threshold. Writes take effect on the edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| quirkMode | input | 1 | 1 selects mask-on-claim behaviour |
| srcLevel | input | NUM_SRC | Level request per source, bit k is ID k+1 |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration address |
| cfgWdata | input | CFG_W | Configuration write data |
| cfgRdata | output | CFG_W | Configuration read data, combinational |
| claimRd | input | NUM_TGT | Claim strobe per target |
| claimData | output | NUM_TGT*ID_W | Claimed ID per target, registered on the claim edge |
| cplWe | input | NUM_TGT | Completion strobe per target |
| cplId | input | NUM_TGT*ID_W | Completed ID per target |
| irq | output | NUM_TGT | Interrupt request per target |

## Verification
The hardest state to reach from the ports is a source stuck in the held state because its completion was refused. This happens when the enable bit was cleared, either by a configuration write or by the mask-on-claim mode. The test can only prove the refusal indirectly. It keeps the source's input high and arranges for another target to still enable that source. A completion that wrongly succeeded would then show up two edges later as a raised irq on that other target. The bench walks there by claiming a pair of equal-priority sources from both targets in the same cycle. It then disables one source for target 0 and completes from the wrong side. After that it switches on the quirk mode and repeats the claim, refused completion, re-enable and accepted completion sequence.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    GW_IDLE = 2'd0,
    GW_PEND = 2'd1,
    GW_HELD = 2'd2
  } gw_state_e;

  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] ENA_BASE = 6'h20;
  localparam logic [ADDR_W-1:0] THR_BASE = 6'h30;
endpackage

// File: rtl/pcc_gateway.sv
module pcc_gateway
  import pcc_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic level,
  input  logic claimHit,
  input  logic cplHit,
  output logic pending
);
  gw_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      GW_IDLE: if (level)    stateNext = GW_PEND;
      GW_PEND: if (claimHit) stateNext = GW_HELD;
      GW_HELD: if (cplHit)   stateNext = GW_IDLE;
      default:               stateNext = GW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GW_IDLE;
    else       state <= stateNext;
  end

  assign pending = (state == GW_PEND);
endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4,
  parameter int CFG_W   = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SRC-1:0]               srcLevel,
  input  logic                             cfgWe,
  input  logic [ADDR_W-1:0]                cfgAddr,
  input  logic [CFG_W-1:0]                 cfgWdata,
  output logic [CFG_W-1:0]                 cfgRdata,
  input  logic [NUM_TGT-1:0]               claimRd,
  input  logic [2*NUM_TGT*NUM_SRC-NUM_TGT*NUM_SRC+2*NUM_SRC-1:0] strobeBus,
  output logic [NUM_TGT-1:0][ID_W-1:0]     pickId,
  output logic [NUM_TGT-1:0][NUM_SRC-1:0]  pickOh,
  output logic [NUM_TGT-1:0][NUM_SRC-1:0]  enMask,
  output logic [NUM_TGT-1:0]               irq
);
  typedef struct packed {
    logic [NUM_TGT-1:0][NUM_SRC-1:0] enClr;
    logic [NUM_SRC-1:0]              claimAny;
    logic [NUM_SRC-1:0]              cplHit;
  } strobe_t;

  strobe_t strobe;
  assign strobe = strobeBus;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ;
  logic [NUM_TGT-1:0][NUM_SRC-1:0] enQ, enD;
  logic [NUM_TGT-1:0][PRIO_W-1:0]  thrQ;
  logic [NUM_SRC-1:0]              pendVec;
  logic [NUM_SRC-1:0]              takenChain [NUM_TGT+1];

  function automatic logic [ID_W-1:0] bestId(input logic [NUM_SRC-1:0] elig,
                                             input logic [NUM_SRC-1:0][PRIO_W-1:0] prio);
    logic [PRIO_W-1:0] bp;
    logic [ID_W-1:0]   bi;
    bp = '0;
    bi = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (elig[i] && prio[i] > bp) begin
        bp = prio[i];
        bi = ID_W'(i + 1);
      end
    return bi;
  endfunction

  function automatic logic [PRIO_W-1:0] topPrio(input logic [NUM_SRC-1:0] elig,
                                                input logic [NUM_SRC-1:0][PRIO_W-1:0] prio);
    logic [PRIO_W-1:0] bp;
    bp = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (elig[i] && prio[i] > bp) bp = prio[i];
    return bp;
  endfunction

  function automatic logic [NUM_SRC-1:0] toOh(input logic [ID_W-1:0] id);
    logic [NUM_SRC-1:0] oh;
    oh = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (id == ID_W'(i + 1)) oh[i] = 1'b1;
    return oh;
  endfunction

  // gateways, one per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    pcc_gateway u_gw (
      .clk     (clk),
      .rstN    (rstN),
      .level   (srcLevel[i]),
      .claimHit(strobe.claimAny[i]),
      .cplHit  (strobe.cplHit[i]),
      .pending (pendVec[i])
    );
  end

  // enable masks: software write first, claim-side clear on top
  always_comb begin
    for (int t = 0; t < NUM_TGT; t++) begin
      enD[t] = (cfgWe && cfgAddr == ENA_BASE + ADDR_W'(t)) ? cfgWdata[NUM_SRC-1:0] : enQ[t];
      enD[t] = enD[t] & ~strobe.enClr[t];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioQ <= '0;
      enQ   <= '0;
      thrQ  <= '0;
    end else begin
      enQ <= enD;
      for (int i = 0; i < NUM_SRC; i++)
        if (cfgWe && cfgAddr == ADDR_W'(i + 1)) prioQ[i] <= cfgWdata[PRIO_W-1:0];
      for (int t = 0; t < NUM_TGT; t++)
        if (cfgWe && cfgAddr == THR_BASE + ADDR_W'(t)) thrQ[t] <= cfgWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (cfgAddr == ADDR_W'(i + 1)) cfgRdata = CFG_W'(prioQ[i]);
    for (int t = 0; t < NUM_TGT; t++) begin
      if (cfgAddr == ENA_BASE + ADDR_W'(t)) cfgRdata = CFG_W'(enQ[t]);
      if (cfgAddr == THR_BASE + ADDR_W'(t)) cfgRdata = CFG_W'(thrQ[t]);
    end
  end

  // per-target selection; lower target index claims first
  assign takenChain[0] = '0;
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign pickId[t] = bestId(pendVec & enQ[t] & ~takenChain[t], prioQ);
    assign pickOh[t] = toOh(pickId[t]);
    assign irq[t]    = topPrio(pendVec & enQ[t], prioQ) > thrQ[t];
    assign takenChain[t+1] = takenChain[t] | (claimRd[t] ? pickOh[t] : '0);
  end

  assign enMask = enQ;
endmodule

// File: rtl/pcc_control.sv
module pcc_control #(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int ID_W    = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             quirkMode,
  input  logic [NUM_TGT-1:0]               claimRd,
  input  logic [NUM_TGT-1:0]               cplWe,
  input  logic [NUM_TGT*ID_W-1:0]          cplId,
  input  logic [NUM_TGT-1:0][ID_W-1:0]     pickId,
  input  logic [NUM_TGT-1:0][NUM_SRC-1:0]  pickOh,
  input  logic [NUM_TGT-1:0][NUM_SRC-1:0]  enMask,
  output logic [2*NUM_TGT*NUM_SRC-NUM_TGT*NUM_SRC+2*NUM_SRC-1:0] strobeBus,
  output logic [NUM_TGT*ID_W-1:0]          claimData
);
  typedef struct packed {
    logic [NUM_TGT-1:0][NUM_SRC-1:0] enClr;
    logic [NUM_SRC-1:0]              claimAny;
    logic [NUM_SRC-1:0]              cplHit;
  } strobe_t;

  strobe_t strobe;
  logic [NUM_TGT-1:0][NUM_SRC-1:0] claimHit;

  always_comb begin
    strobe   = '0;
    claimHit = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      claimHit[t] = claimRd[t] ? pickOh[t] : '0;
      strobe.claimAny = strobe.claimAny | claimHit[t];
      if (quirkMode) strobe.enClr[t] = claimHit[t];
      for (int i = 0; i < NUM_SRC; i++)
        if (cplWe[t] && cplId[t*ID_W +: ID_W] == ID_W'(i + 1) && enMask[t][i])
          strobe.cplHit[i] = 1'b1;
    end
  end

  assign strobeBus = strobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) claimData <= '0;
    else
      for (int t = 0; t < NUM_TGT; t++)
        if (claimRd[t]) claimData[t*ID_W +: ID_W] <= pickId[t];
  end
endmodule

// File: rtl/pcc_top.sv
module pcc_top
  import pcc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC + 1),
  localparam int CFG_W  = (NUM_SRC > PRIO_W) ? NUM_SRC : PRIO_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    quirkMode,
  input  logic [NUM_SRC-1:0]      srcLevel,
  input  logic                    cfgWe,
  input  logic [5:0]              cfgAddr,
  input  logic [CFG_W-1:0]        cfgWdata,
  output logic [CFG_W-1:0]        cfgRdata,
  input  logic [NUM_TGT-1:0]      claimRd,
  output logic [NUM_TGT*ID_W-1:0] claimData,
  input  logic [NUM_TGT-1:0]      cplWe,
  input  logic [NUM_TGT*ID_W-1:0] cplId,
  output logic [NUM_TGT-1:0]      irq
);
  localparam int STB_W = NUM_TGT*NUM_SRC + 2*NUM_SRC;

  logic [STB_W-1:0]                strobeBus;
  logic [NUM_TGT-1:0][ID_W-1:0]    pickId;
  logic [NUM_TGT-1:0][NUM_SRC-1:0] pickOh;
  logic [NUM_TGT-1:0][NUM_SRC-1:0] enMask;

  pcc_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .PRIO_W(PRIO_W), .ID_W(ID_W), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .claimRd(claimRd), .strobeBus(strobeBus),
    .pickId(pickId), .pickOh(pickOh), .enMask(enMask), .irq(irq)
  );

  pcc_control #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .ID_W(ID_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .quirkMode(quirkMode),
    .claimRd(claimRd), .cplWe(cplWe), .cplId(cplId),
    .pickId(pickId), .pickOh(pickOh), .enMask(enMask),
    .strobeBus(strobeBus), .claimData(claimData)
  );
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int NUM_SRC = 8,
  parameter int NUM_TGT = 2,
  parameter int ID_W    = 4
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            quirkMode,
  input logic                            cfgWe,
  input logic [NUM_TGT-1:0]              claimRd,
  input logic [NUM_TGT*ID_W-1:0]         claimData,
  input logic [NUM_TGT-1:0]              irq,
  input logic [NUM_TGT-1:0][NUM_SRC-1:0] enMask
);
  // R3
  irq_claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd[0] && irq[0]) |=> (claimData[ID_W-1:0] != '0));

  // R4
  no_double_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd[0] && $past(claimRd[0]) && claimData[ID_W-1:0] != '0)
      |=> (claimData[ID_W-1:0] != $past(claimData[ID_W-1:0])));

  // R9
  enable_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!quirkMode && !cfgWe) |=> (enMask == $past(enMask)));

  if (NUM_TGT > 1) begin : g_pair
    // R8
    split_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
      (claimRd[1:0] == 2'b11)
        |=> (claimData[ID_W-1:0] == '0 || claimData[ID_W-1:0] != claimData[2*ID_W-1:ID_W]));
  end
endmodule

bind pcc_top pcc_checker #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .ID_W(ID_W)) u_pcc_checker (
  .clk(clk), .rstN(rstN), .quirkMode(quirkMode), .cfgWe(cfgWe),
  .claimRd(claimRd), .claimData(claimData), .irq(irq), .enMask(enMask)
);

// File: tb/pcc_top_bench.sv
module pcc_top_bench;
  localparam int NSRC = 8;
  localparam int NTGT = 2;
  localparam int IDW  = 4;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic quirkMode = 1'b0;
  logic [NSRC-1:0] srcLevel = '0;
  logic cfgWe = 1'b0;
  logic [5:0] cfgAddr = '0;
  logic [CW-1:0] cfgWdata = '0;
  logic [CW-1:0] cfgRdata;
  logic [NTGT-1:0] claimRd = '0;
  logic [NTGT*IDW-1:0] claimData;
  logic [NTGT-1:0] cplWe = '0;
  logic [NTGT*IDW-1:0] cplId = '0;
  logic [NTGT-1:0] irq;

  always #5 clk = ~clk;

  pcc_top u_pcc_top (
    .clk(clk), .rstN(rstN), .quirkMode(quirkMode), .srcLevel(srcLevel),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .claimRd(claimRd), .claimData(claimData), .cplWe(cplWe), .cplId(cplId), .irq(irq)
  );

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;
  string tagQ[$];
  int selQ[$];
  int expQ[$];
  event pushEv;

  function automatic int sampleOut(int s);
    case (s)
      0: return int'(claimData[IDW-1:0]);
      1: return int'(claimData[2*IDW-1:IDW]);
      2: return int'(irq);
      default: return int'(cfgRdata);
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(pushEv);
      while (selQ.size() > 0) begin
        string tg;
        int s;
        int e;
        int a;
        tg = tagQ.pop_front();
        s  = selQ.pop_front();
        e  = expQ.pop_front();
        a  = sampleOut(s);
        nVec++;
        if (a != e) begin
          nBad++;
          $display("FAIL %s: actual %0d expected %0d", tg, a, e);
        end
      end
    end
  end

  task automatic chk(input string tg, input int s, input int e);
    tagQ.push_back(tg);
    selQ.push_back(s);
    expQ.push_back(e);
    ->pushEv;
    #0;
  endtask

  task automatic cfgWrite(input int a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 6'(a); cfgWdata = CW'(d);
    @(posedge clk); #2;
    cfgWe = 1'b0;
  endtask

  task automatic readCfg(input int a, input string tg, input int e);
    @(negedge clk);
    cfgAddr = 6'(a);
    #1;
    chk(tg, 3, e);
  endtask

  task automatic setLevel(input int v);
    @(negedge clk);
    srcLevel = NSRC'(v);
    @(posedge clk); #2;
  endtask

  task automatic claim(input int m);
    @(negedge clk);
    claimRd = NTGT'(m);
    @(posedge clk); #2;
    claimRd = '0;
  endtask

  task automatic complete(input int t, input int id);
    @(negedge clk);
    cplWe[t] = 1'b1;
    cplId[t*IDW +: IDW] = IDW'(id);
    @(posedge clk); #2;
    cplWe = '0;
  endtask

  task automatic idle();
    @(negedge clk);
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 claim0", 0, 0);
    chk("R1 claim1", 1, 0);
    chk("R1 irq", 2, 0);
    readCfg(1, "R1 prio1", 0);
    readCfg(6'h20, "R1 enable0", 0);

    // configuration
    cfgWrite(1, 2); cfgWrite(2, 5); cfgWrite(3, 5); cfgWrite(4, 1);
    cfgWrite(5, 0); cfgWrite(6, 3); cfgWrite(7, 3); cfgWrite(8, 3);
    cfgWrite(6'h20, 8'hFF); cfgWrite(6'h21, 8'hFF); cfgWrite(6'h31, 4);
    readCfg(2, "R10 prio2", 5);
    readCfg(6'h20, "R10 enable0", 255);
    readCfg(6'h31, "R10 thresh1", 4);

    // priority-0 source never wins
    setLevel(8'h10);
    chk("R2 irq prio0", 2, 0);
    claim(1);
    chk("R2 claim prio0", 0, 0);

    // equal priorities, simultaneous claims
    setLevel(8'h16);
    chk("R3 irq both", 2, 3);
    claim(3);
    chk("R8 claim0 tie", 0, 2);
    chk("R8 claim1 next", 1, 3);
    chk("R4 irq after claim", 2, 0);
    claim(1);
    chk("R4 held not reclaimed", 0, 0);

    // another source still interrupts while two are held
    setLevel(8'h17);
    chk("R7 irq other source", 2, 1);
    claim(2);
    chk("R2 claim below threshold", 1, 1);

    // refused completions
    complete(0, 0);
    idle();
    chk("R5 id0 no effect", 2, 0);
    cfgWrite(6'h20, 8'hFD);
    complete(0, 2);
    idle();
    chk("R5 disabled id refused", 2, 0);

    // accepted completion and re-pend timing
    complete(1, 2);
    chk("R6 not yet pending", 2, 0);
    idle();
    chk("R6 pending again", 2, 2);
    claim(1);
    chk("R5 disabled not claimed", 0, 0);
    claim(2);
    chk("R6 reclaim", 1, 2);
    readCfg(6'h21, "R9 compliant enable kept", 255);

    // mask-on-claim mode
    @(negedge clk);
    quirkMode = 1'b1;
    complete(1, 3);
    idle();
    chk("R6 source3 pending", 2, 3);
    claim(2);
    chk("R9 quirk claim", 1, 3);
    readCfg(6'h21, "R9 quirk enable1 cleared", 8'hFB);
    readCfg(6'h20, "R9 quirk enable0 kept", 8'hFD);
    complete(1, 3);
    idle();
    chk("R9 completion refused", 2, 0);
    cfgWrite(6'h21, 8'hFF);
    complete(1, 3);
    idle();
    chk("R9 completion after reenable", 2, 3);
    claim(1);
    chk("R9 quirk claim t0", 0, 3);
    readCfg(6'h20, "R9 quirk enable0 cleared", 8'hF9);

    #5;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule